// File: doc/BRIEF.md
# PCI configuration port decoder

This block sits on the host I/O request path and implements the two-port configuration access mechanism. A 32-bit word written to the address port selects a bus, a device/function and a register dword, together with an enable bit. Accesses to the four data-port byte addresses then go to the attached function that owns the selected device/function. The access carries a register byte offset that combines the latched dword offset with the low two bits of the port address.

A 256-entry map translates each device/function index to a slot number, one slot for each attached function register file. A registration port loads this map, handing out slots in ascending order. The block forwards a configuration request (slot, register offset, length, write data) to the selected function and returns that function's read data. When no function can answer, it returns all ones. It keeps a shadow of the last data-port value. I/O requests arrive on a valid/ready channel and each accepted request produces exactly one response on a second valid/ready channel. The block stalls new requests (io_ready low) while a response is waiting and rsp_ready is low. A pending response holds all its fields until it is taken.

Top module: `pcicfg_port_decoder`

## Requirements
- R1: A write to port 0x0CF8 with length 4 loads the 32-bit address register. A write there with length 1 or 2 leaves it unchanged.
- R2: A read of port 0x0CF8 with length 4 returns the address register. A read there with length 1 or 2 returns 0x0000FFFF.
- R3: A data-port access (ports 0x0CFC..0x0CFF) can reach a function only when address bit 31 is 1 and address bits 23:16 are zero. Otherwise nothing is forwarded, and a read returns 0xFFFFFFFF.
- R4: The device/function index is address bits 15:8. The forwarded register offset is address bits 7:2 with two zero low bits, plus port bits 1:0. Length and write data pass through unchanged.
- R5: A data-port access whose device/function index is unmapped forwards nothing, and a read of it returns 0xFFFFFFFF.
- R6: Registration gives slots 0, 1, 2 ... in request order. It fails, leaving the map unchanged, when the index is already mapped or when all NUM_SLOTS slots are taken. Results appear one cycle after the request.
- R7: A data-port write is forwarded only when its register offset is 4..7, 12, 13 or greater than 14. Writes to any other offset are dropped.
- R8: The last-data shadow takes every data-port read result. After a forwarded write it takes the write data shifted left by 8 times port bits 1:0, truncated to 32 bits. A dropped write leaves it unchanged.
- R9: After reset the address register and the shadow are zero, no index is mapped, and no response is pending.
- R10: A request to any other port returns a response with rsp_err set and data 0xFFFFFFFF, forwards nothing and changes no state.
- R11: Each accepted request yields one response in the next cycle. Write responses carry data zero. io_ready is low while a response is held with rsp_ready low, and a held response keeps its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O request valid |
| io_ready | output | 1 | I/O request accepted when high with io_valid |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port address |
| io_len | input | 3 | Byte length: 1, 2 or 4 |
| io_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_data | output | 32 | Read data (zero for writes, all ones on error) |
| rsp_err | output | 1 | Request hit an unsupported port |
| reg_req | input | 1 | Registration request strobe |
| reg_devfn | input | 8 | Device/function index to register |
| reg_done | output | 1 | Registration result valid (one cycle) |
| reg_ok | output | 1 | Registration succeeded |
| reg_slot | output | SLOT_W | Slot given on success |
| cfg_valid | output | 1 | Forwarded configuration request valid |
| cfg_write | output | 1 | Forwarded request is a write |
| cfg_slot | output | SLOT_W | Target slot |
| cfg_reg | output | 8 | Register byte offset |
| cfg_len | output | 3 | Byte length |
| cfg_wdata | output | 32 | Write data |
| cfg_rdata | input | 32 | Read data from target, same cycle |
| shadow_data | output | 32 | Last data-port value |

## Verification
The assertions check on every cycle that forwarded requests only go out with the enable bit set and bus zero, to a mapped slot, and for writes only to a writable offset. They also check that narrow address writes leave the address register alone, that held responses stay stable with io_ready low, and that the slot count never passes its limit. Only the bench scenarios can show the values involved: the decoded register offset, the slot order and the failures from registration, the all-ones and 0xFFFF returns, and the shifted shadow contents. The bench compares these against a reference model under random port, length and address mixes.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam logic [15:0] PORT_ADDR      = 16'h0CF8;
  localparam logic [13:0] PORT_DATA_HI   = 14'h033F; // 0x0CFC >> 2
  localparam logic [31:0] ALL_ONES       = 32'hFFFF_FFFF;
  localparam logic [31:0] NARROW_ADDR_RD = 32'h0000_FFFF;
  localparam logic [31:0] HIT_MASK       = 32'h80FF_0000;
  localparam logic [31:0] HIT_MATCH      = 32'h8000_0000;
  localparam int          DEVFN_COUNT    = 256;

  typedef enum logic [1:0] {PK_ADDR, PK_DATA, PK_OTHER} port_kind_e;

  function automatic port_kind_e classify(input logic [15:0] port);
    if (port == PORT_ADDR)              return PK_ADDR;
    else if (port[15:2] == PORT_DATA_HI) return PK_DATA;
    else                                 return PK_OTHER;
  endfunction

  function automatic logic offset_writable(input logic [7:0] off);
    return ((off >= 8'd4) && (off <= 8'd7)) || (off == 8'd12) ||
           (off == 8'd13) || (off > 8'd14);
  endfunction
endpackage

// File: rtl/pcicfg_addr_latch.sv
module pcicfg_addr_latch
  import pcicfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] addr_q,
  output logic        target_ok,
  output logic [7:0]  devfn,
  output logic [5:0]  dword_off
);
  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= wr_data;
  end

  assign target_ok = (addr_q & HIT_MASK) == HIT_MATCH;
  assign devfn     = addr_q[15:8];
  assign dword_off = addr_q[7:2];
endmodule

// File: rtl/pcicfg_slot_map.sv
module pcicfg_slot_map
  import pcicfg_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic [7:0]        reg_devfn,
  output logic              reg_done,
  output logic              reg_ok,
  output logic [SLOT_W-1:0] reg_slot,
  input  logic [7:0]        lookup_devfn,
  output logic [SLOT_W-1:0] lookup_slot,
  output logic              lookup_hit
);
  localparam logic [SLOT_W-1:0] NONE = SLOT_W'(NUM_SLOTS);

  logic [SLOT_W-1:0] tbl [DEVFN_COUNT];
  logic [SLOT_W-1:0] count_q;
  logic              can_map;

  assign can_map = (tbl[reg_devfn] == NONE) && (count_q < NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEVFN_COUNT; i++) tbl[i] <= NONE;
      count_q  <= '0;
      reg_done <= 1'b0;
      reg_ok   <= 1'b0;
      reg_slot <= '0;
    end else begin
      reg_done <= reg_req;
      reg_ok   <= reg_req && can_map;
      reg_slot <= (reg_req && can_map) ? count_q : '0;
      if (reg_req && can_map) begin
        tbl[reg_devfn] <= count_q;
        count_q        <= count_q + 1'b1;
      end
    end
  end

  assign lookup_slot = tbl[lookup_devfn];
  assign lookup_hit  = lookup_slot != NONE;

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= NONE);
  a_r6_no_req_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_req |=> $stable(count_q));
endmodule

// File: rtl/pcicfg_route.sv
module pcicfg_route
  import pcicfg_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              accept,
  input  logic              io_write,
  input  logic [15:0]       io_port,
  input  logic [2:0]        io_len,
  input  logic [31:0]       io_wdata,
  input  logic [31:0]       addr_q,
  input  logic              target_ok,
  input  logic [5:0]        dword_off,
  input  logic              slot_hit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [31:0]       cfg_rdata,
  output logic              addr_we,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic [SLOT_W-1:0] cfg_slot,
  output logic [7:0]        cfg_reg,
  output logic [2:0]        cfg_len,
  output logic [31:0]       cfg_wdata,
  output logic [31:0]       rsp_value,
  output logic              rsp_is_err,
  output logic              shadow_we,
  output logic [31:0]       shadow_val
);
  port_kind_e kind;
  logic       reachable;
  logic [4:0] shamt;

  assign kind      = classify(io_port);
  assign cfg_reg   = {dword_off, 2'b00} + {6'd0, io_port[1:0]};
  assign reachable = target_ok && slot_hit;
  assign shamt     = {io_port[1:0], 3'b000};
  assign cfg_slot  = slot;
  assign cfg_len   = io_len;
  assign cfg_wdata = io_wdata;
  assign cfg_write = io_write;

  always_comb begin
    addr_we    = 1'b0;
    cfg_valid  = 1'b0;
    rsp_value  = '0;
    rsp_is_err = 1'b0;
    shadow_we  = 1'b0;
    shadow_val = '0;
    unique case (kind)
      PK_ADDR: begin
        if (io_write) addr_we = accept && (io_len == 3'd4);
        else          rsp_value = (io_len == 3'd4) ? addr_q : NARROW_ADDR_RD;
      end
      PK_DATA: begin
        if (io_write) begin
          cfg_valid  = accept && reachable && offset_writable(cfg_reg);
          shadow_we  = cfg_valid;
          shadow_val = io_wdata << shamt;
        end else begin
          cfg_valid  = accept && reachable;
          rsp_value  = reachable ? cfg_rdata : ALL_ONES;
          shadow_we  = accept;
          shadow_val = rsp_value;
        end
      end
      default: begin
        rsp_value  = ALL_ONES;
        rsp_is_err = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pcicfg_port_decoder.sv
module pcicfg_port_decoder
  import pcicfg_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  output logic              io_ready,
  input  logic              io_write,
  input  logic [15:0]       io_port,
  input  logic [2:0]        io_len,
  input  logic [31:0]       io_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  input  logic              reg_req,
  input  logic [7:0]        reg_devfn,
  output logic              reg_done,
  output logic              reg_ok,
  output logic [SLOT_W-1:0] reg_slot,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic [SLOT_W-1:0] cfg_slot,
  output logic [7:0]        cfg_reg,
  output logic [2:0]        cfg_len,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata,
  output logic [31:0]       shadow_data
);
  logic              accept;
  logic              addr_we;
  logic [31:0]       addr_q;
  logic              target_ok;
  logic [7:0]        devfn;
  logic [5:0]        dword_off;
  logic [SLOT_W-1:0] lk_slot;
  logic              lk_hit;
  logic [31:0]       rsp_value;
  logic              rsp_is_err;
  logic              shadow_we;
  logic [31:0]       shadow_val;

  assign io_ready = !rsp_valid || rsp_ready;
  assign accept   = io_valid && io_ready;

  pcicfg_addr_latch u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(addr_we), .wr_data(io_wdata),
    .addr_q(addr_q), .target_ok(target_ok), .devfn(devfn), .dword_off(dword_off)
  );

  pcicfg_slot_map #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_map (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_devfn(reg_devfn),
    .reg_done(reg_done), .reg_ok(reg_ok), .reg_slot(reg_slot),
    .lookup_devfn(devfn), .lookup_slot(lk_slot), .lookup_hit(lk_hit)
  );

  pcicfg_route #(.SLOT_W(SLOT_W)) u_route (
    .accept(accept), .io_write(io_write), .io_port(io_port), .io_len(io_len),
    .io_wdata(io_wdata), .addr_q(addr_q), .target_ok(target_ok),
    .dword_off(dword_off), .slot_hit(lk_hit), .slot(lk_slot),
    .cfg_rdata(cfg_rdata), .addr_we(addr_we), .cfg_valid(cfg_valid),
    .cfg_write(cfg_write), .cfg_slot(cfg_slot), .cfg_reg(cfg_reg),
    .cfg_len(cfg_len), .cfg_wdata(cfg_wdata), .rsp_value(rsp_value),
    .rsp_is_err(rsp_is_err), .shadow_we(shadow_we), .shadow_val(shadow_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_err     <= 1'b0;
      shadow_data <= '0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rsp_value;
        rsp_err   <= rsp_is_err;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (shadow_we) shadow_data <= shadow_val;
    end
  end

  a_r1_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && io_write && io_port == PORT_ADDR && io_len != 3'd4) |=> $stable(addr_q));
  a_r3_enable_bus0: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (addr_q[31] && addr_q[23:16] == 8'h00));
  a_r5_mapped_only: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_slot < SLOT_W'(NUM_SLOTS)));
  a_r7_write_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write) |-> !(cfg_reg < 8'd4 || (cfg_reg > 8'd7 && cfg_reg < 8'd12) || cfg_reg == 8'd14));
  a_r10_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_data == ALL_ONES);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !io_ready);
endmodule

// File: tb/test_pcicfg_port_decoder.sv
module test_pcicfg_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_port = '0;
  logic [2:0]  io_len = 3'd4;
  logic [31:0] io_wdata = '0;
  logic        io_ready, rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        reg_req = 1'b0;
  logic [7:0]  reg_devfn = '0;
  logic        reg_done, reg_ok;
  logic [3:0]  reg_slot;
  logic        cfg_valid, cfg_write;
  logic [3:0]  cfg_slot;
  logic [7:0]  cfg_reg;
  logic [2:0]  cfg_len;
  logic [31:0] cfg_wdata, cfg_rdata, shadow_data;

  int n_checks = 0, n_errors = 0;
  int m_tbl [256];
  int m_count = 0;
  logic [31:0] m_addr = '0, m_shadow = '0;
  logic [7:0] known [8];

  always #5 clk = ~clk;

  assign cfg_rdata = {4'hA, cfg_slot, 8'h3C, cfg_reg, ~cfg_reg};

  pcicfg_port_decoder i_pcicfg_port_decoder (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_ready(io_ready),
    .io_write(io_write), .io_port(io_port), .io_len(io_len), .io_wdata(io_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .reg_req(reg_req), .reg_devfn(reg_devfn), .reg_done(reg_done), .reg_ok(reg_ok),
    .reg_slot(reg_slot), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_slot(cfg_slot), .cfg_reg(cfg_reg), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .shadow_data(shadow_data)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic writable(input logic [7:0] r);
    return (r >= 4 && r <= 7) || r == 12 || r == 13 || r > 14;
  endfunction

  task automatic do_io(input logic [15:0] port, input logic wr, input logic [2:0] len, input logic [31:0] wd);
    logic e_err, e_fwd, hit;
    logic [31:0] e_rsp;
    logic [7:0] e_reg;
    logic [3:0] e_slot;
    logic c_v, c_w;
    logic [3:0] c_s;
    logic [7:0] c_r;
    logic [2:0] c_l;
    logic [31:0] c_d;
    e_err = 1'b0; e_fwd = 1'b0; e_rsp = '0;
    e_reg = {m_addr[7:2], 2'b00} + {6'd0, port[1:0]};
    hit = ((m_addr & 32'h80FF0000) == 32'h80000000) && (m_tbl[m_addr[15:8]] >= 0);
    e_slot = hit ? 4'(m_tbl[m_addr[15:8]]) : 4'd0;
    if (port == 16'h0CF8) begin
      if (wr) begin if (len == 3'd4) m_addr = wd; end
      else e_rsp = (len == 3'd4) ? m_addr : 32'h0000FFFF;
    end else if (port[15:2] == 14'h033F) begin
      if (wr) begin
        e_fwd = hit && writable(e_reg);
        if (e_fwd) m_shadow = wd << (8 * port[1:0]);
      end else begin
        e_fwd = hit;
        e_rsp = hit ? {4'hA, e_slot, 8'h3C, e_reg, ~e_reg} : 32'hFFFFFFFF;
        m_shadow = e_rsp;
      end
    end else begin
      e_err = 1'b1; e_rsp = 32'hFFFFFFFF;
    end
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_port = port; io_len = len; io_wdata = wd;
    #1;
    c_v = cfg_valid; c_w = cfg_write; c_s = cfg_slot; c_r = cfg_reg; c_l = cfg_len; c_d = cfg_wdata;
    @(negedge clk);
    io_valid = 1'b0;
    chk(c_v == e_fwd, "R3/R5/R7/R10 forward", {31'd0, c_v}, {31'd0, e_fwd});
    if (e_fwd)
      chk(c_w == wr && c_s == e_slot && c_r == e_reg && c_l == len && c_d == wd,
          "R4 fields", {c_s, c_r, c_l, 17'd0}, {e_slot, e_reg, len, 17'd0});
    chk(rsp_valid && rsp_data == e_rsp, "R2/R3/R5/R11 rsp_data", rsp_data, e_rsp);
    chk(rsp_err == e_err, "R10 rsp_err", {31'd0, rsp_err}, {31'd0, e_err});
    chk(shadow_data == m_shadow, "R8 shadow", shadow_data, m_shadow);
  endtask

  task automatic do_reg(input logic [7:0] dfn);
    logic e_ok;
    e_ok = (m_tbl[dfn] < 0) && (m_count < 8);
    @(negedge clk);
    reg_req = 1'b1; reg_devfn = dfn;
    @(negedge clk);
    reg_req = 1'b0;
    chk(reg_done && reg_ok == e_ok && (!e_ok || reg_slot == 4'(m_count)),
        "R6 registration", {reg_ok, 27'd0, reg_slot}, {e_ok, 27'd0, 4'(m_count)});
    if (e_ok) begin m_tbl[dfn] = m_count; known[m_count] = dfn; m_count++; end
  endtask

  initial begin : watchdog
    #1500000;
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) m_tbl[i] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!rsp_valid && shadow_data == 0 && !cfg_valid, "R9 reset outputs", shadow_data, 0);
    do_io(16'h0CF8, 1'b0, 3'd4, 0);                  // R9 address zero
    do_io(16'h0CFC, 1'b0, 3'd4, 0);                  // R3 disabled read
    do_io(16'h0CF8, 1'b1, 3'd4, 32'h8000_0000);
    do_io(16'h0CFC, 1'b0, 3'd4, 0);                  // R5/R9 unmapped
    // R6 registrations, duplicate, overflow
    do_reg(8'h00); do_reg(8'h08); do_reg(8'h08); do_reg(8'h13);
    for (int i = 0; i < 5; i++) do_reg(8'h40 + 8'(i * 8));
    do_reg(8'hF0);
    // R1/R2 narrow address port
    do_io(16'h0CF8, 1'b1, 3'd2, 32'h8000_1304);
    do_io(16'h0CF8, 1'b0, 3'd2, 0);
    do_io(16'h0CF8, 1'b0, 3'd4, 0);
    // R4/R7 boundaries around offsets 12..15 and 0..3
    do_io(16'h0CF8, 1'b1, 3'd4, 32'h8000_080C);
    for (int p = 0; p < 4; p++) do_io(16'h0CFC + 16'(p), 1'b1, 3'd1, 32'h0000_00A5);
    for (int p = 0; p < 4; p++) do_io(16'h0CFC + 16'(p), 1'b0, 3'd1, 0);
    do_io(16'h0CF8, 1'b1, 3'd4, 32'h8000_0800);
    do_io(16'h0CFD, 1'b1, 3'd2, 32'h1234_5678);
    do_io(16'h0CF8, 1'b1, 3'd4, 32'h8001_0804);      // R3 nonzero bus
    do_io(16'h0CFC, 1'b1, 3'd4, 32'hDEAD_BEEF);
    // R10 unsupported ports
    do_io(16'h0CF9, 1'b1, 3'd4, 32'h1111_1111);
    do_io(16'h0080, 1'b0, 3'd1, 0);
    do_io(16'h0CF8, 1'b0, 3'd4, 0);
    // R11 back-pressure
    rsp_ready = 1'b0;
    do_io(16'h0CF8, 1'b0, 3'd4, 0);
    held = rsp_data;
    io_valid = 1'b1; io_write = 1'b1; io_port = 16'h0CF8; io_len = 3'd4; io_wdata = 32'h0;
    #1;
    chk(!io_ready && !cfg_valid, "R11 stall", {31'd0, io_ready}, 0);
    @(negedge clk);
    chk(rsp_valid && rsp_data == held, "R11 hold", rsp_data, held);
    rsp_ready = 1'b1;
    @(negedge clk);                                   // accepted now
    io_valid = 1'b0;
    m_addr = 32'h0;
    @(negedge clk);
    do_io(16'h0CF8, 1'b0, 3'd4, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [31:0] a;
      sel = $urandom_range(0, 9);
      if (sel < 3) begin
        a = $urandom;
        a[31] = ($urandom_range(0, 7) != 0);
        if ($urandom_range(0, 5) != 0) a[23:16] = 0;
        if ($urandom_range(0, 3) != 0) a[15:8] = known[$urandom_range(0, 7)];
        do_io(16'h0CF8, 1'b1, ($urandom_range(0, 4) == 0) ? 3'd1 : 3'd4, a);
      end else if (sel < 9) begin
        do_io(16'h0CFC + 16'($urandom_range(0, 3)), 1'($urandom),
              3'd1 << $urandom_range(0, 2), $urandom);
      end else begin
        do_io(($urandom_range(0, 1) != 0) ? 16'h0CF8 : 16'h0CFA, 1'($urandom),
              3'd1 << $urandom_range(0, 2), $urandom);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule